// File: doc/BRIEF.md
# Write-Once System Option Controller

This block holds a small set of system options in an 8-bit register on a simple read/write port. After each reset the four implemented option bits are zero and can be written exactly once; every later write is dropped until the next reset. The options drive the block's timing logic directly. A watchdog counter raises a reset request when it is not serviced in time, and one option selects between its two timeout periods while another switches it off. A stop sequencer decides whether a stop request is legal. Once stopped, it waits out a short or long recovery delay after a wake-up before it signals that recovery is done.

A wake-up can come from an ordinary wake request or from a reset-sourced exit. A reset-sourced exit always takes the long recovery delay, whatever the short-recovery option says. The CPU core, the oscillator and clock generation sit outside the block; every count is in cycles of `clk`.

Top module: `sysopt_ctrl`

## Requirements
- R1: After reset the option register reads 0x00 at address 0x1F, and `wd_rst_req`, `rec_done` and `stop_illegal` are low.
- R2: The first write to address 0x1F after reset stores write-data bits 3:0 (bit 3 short recovery, bit 2 short watchdog period, bit 1 stop allowed, bit 0 watchdog off). Read bits 7:4 are always 0.
- R3: Once the first write to 0x1F has been taken, later writes leave the register unchanged until reset. Writes to any other address neither change the register nor lock it.
- R4: With bit 3 at 1, `rec_done` rises exactly 32 cycles after the clock edge that samples `wake_req` in the stopped state, for one cycle.
- R5: With bit 3 at 0, the recovery delay after `wake_req` is 4096 cycles.
- R6: A `wake_rst` exit from the stopped state always takes the 4096-cycle delay, even with bit 3 at 1.
- R7: With bit 0 at 0 the watchdog raises `wd_rst_req` for one cycle every 2^WD_SHORT_EXP − 2^WD_SUB_EXP cycles (bit 2 at 1) or 2^WD_LONG_EXP − 2^WD_SUB_EXP cycles (bit 2 at 0). The period is counted from reset release or from the previous request.
- R8: A cycle with `wd_service` high clears the watchdog count, so the next request comes one full period after the clock edge that samples the service.
- R9: With bit 0 at 1 the watchdog never raises `wd_rst_req`.
- R10: A `stop_req` while running with bit 1 at 0 raises `stop_illegal` for exactly the following cycle and does not enter the stopped state, so a later wake request produces no `rec_done`.
- R11: A `stop_req` with bit 1 at 1 enters the stopped state without flagging. Wake requests while running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when the option register is not addressed |
| wd_service | input | 1 | Watchdog service strobe |
| stop_req | input | 1 | Request to enter the stopped state |
| wake_req | input | 1 | Ordinary wake-up from the stopped state |
| wake_rst | input | 1 | Reset-sourced wake-up from the stopped state |
| wd_rst_req | output | 1 | One-cycle watchdog timeout request |
| rec_done | output | 1 | One-cycle pulse when the recovery delay has elapsed |
| stop_illegal | output | 1 | One-cycle flag for a stop request that is not allowed |

## Verification
The hardest case to reach from the ports is the reset-sourced exit with short recovery selected. It shows up only when the lock has been set to the short option and the block sits in the stopped state. Only then can the choice of exit source override the option. The bench writes the short option, enters the stopped state twice, and leaves once by each wake source, expecting 32 and then 4096 cycles. The watchdog periods run with reduced exponents, so several full timeouts, and a service placed mid-period, fit inside the run.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;

  // Option bits, in the positions the bus decodes.
  typedef struct packed {
    logic short_rec;  // bit 3
    logic wd_short;   // bit 2
    logic stop_en;    // bit 1
    logic wd_off;     // bit 0
  } cfg_bits_t;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_STOP = 2'd1,
    PH_WAKE = 2'd2
  } phase_t;

  // Watchdog timeout in cycles: 2^exp_bits - 2^sub_bits.
  function automatic int unsigned wd_limit(input int unsigned exp_bits,
                                           input int unsigned sub_bits);
    return (32'd1 << exp_bits) - (32'd1 << sub_bits);
  endfunction

  // Recovery delay: a reset-sourced exit always takes the long delay.
  function automatic int unsigned wake_delay(input logic short_sel,
                                             input logic via_rst,
                                             input int unsigned short_cyc,
                                             input int unsigned long_cyc);
    return (short_sel && !via_rst) ? short_cyc : long_cyc;
  endfunction

endpackage

// File: rtl/cfg_once_reg.sv
module cfg_once_reg
  import cfgwd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_ADDR = 32'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_bits_t         cfg_q,
  output logic              locked_q,
  output logic              wr_hit
);

  localparam int unsigned IMPL = $bits(cfg_bits_t);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  logic addr_hit;
  logic take_write;
  logic unused_hi;

  assign addr_hit   = sel && (addr == MY_ADDR);
  assign wr_hit     = addr_hit && wr;
  assign take_write = wr_hit && !locked_q;
  assign unused_hi  = ^wdata[DATA_W-1:IMPL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      locked_q <= 1'b0;
    end else if (take_write) begin
      cfg_q    <= cfg_bits_t'(wdata[IMPL-1:0]);
      locked_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr_hit) rdata[IMPL-1:0] = cfg_q;
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import cfgwd_pkg::*;
#(
  parameter int unsigned LONG_EXP  = 18,
  parameter int unsigned SHORT_EXP = 13,
  parameter int unsigned SUB_EXP   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_off,
  input  logic short_sel,
  input  logic service,
  output logic expire_q,
  output logic hit_now
);

  localparam int unsigned CNT_W = LONG_EXP;
  localparam int unsigned LIM_L = wd_limit(LONG_EXP, SUB_EXP);
  localparam int unsigned LIM_S = wd_limit(SHORT_EXP, SUB_EXP);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(LIM_L - 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(LIM_S - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last    = short_sel ? LAST_S : LAST_L;
  // A count already past the new limit (period shortened) ends at once.
  assign hit_now = !wd_off && !service && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (wd_off || service) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else if (hit_now) begin
      cnt_q    <= '0;
      expire_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      expire_q <= 1'b0;
    end
  end

endmodule

// File: rtl/stop_seq.sv
module stop_seq
  import cfgwd_pkg::*;
#(
  parameter int unsigned SHORT_REC = 32,
  parameter int unsigned LONG_REC  = 4096
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stop_en,
  input  logic   short_rec,
  input  logic   stop_req,
  input  logic   wake_req,
  input  logic   wake_rst,
  output phase_t phase_q,
  output logic   done_q,
  output logic   illegal_q
);

  localparam int unsigned CNT_W = $clog2(LONG_REC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(wake_delay(short_rec, wake_rst, SHORT_REC, LONG_REC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_RUN;
      cnt_q     <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      case (phase_q)
        PH_RUN: begin
          if (stop_req) begin
            if (stop_en) phase_q   <= PH_STOP;
            else         illegal_q <= 1'b1;
          end
        end
        PH_STOP: begin
          if (wake_req || wake_rst) begin
            cnt_q   <= load_val;
            phase_q <= PH_WAKE;
          end
        end
        PH_WAKE: begin
          if (cnt_q <= CNT_W'(1)) begin
            cnt_q   <= '0;
            phase_q <= PH_RUN;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: phase_q <= PH_RUN;
      endcase
    end
  end

endmodule

// File: rtl/sysopt_ctrl.sv
module sysopt_ctrl
  import cfgwd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned CFG_ADDR     = 32'h1F,
  parameter int unsigned WD_LONG_EXP  = 18,
  parameter int unsigned WD_SHORT_EXP = 13,
  parameter int unsigned WD_SUB_EXP   = 4,
  parameter int unsigned REC_SHORT    = 32,
  parameter int unsigned REC_LONG     = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              wd_service,
  input  logic              stop_req,
  input  logic              wake_req,
  input  logic              wake_rst,
  output logic              wd_rst_req,
  output logic              rec_done,
  output logic              stop_illegal
);

  localparam int unsigned DATA_W = 8;

  // Named internal events for the checker.
  cfg_bits_t cfg_q;
  logic      cfg_locked;
  logic      cfg_wr_hit;
  logic      wd_hit_now;
  phase_t    seq_phase;

  cfg_once_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .REG_ADDR(CFG_ADDR)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .cfg_q   (cfg_q),
    .locked_q(cfg_locked),
    .wr_hit  (cfg_wr_hit)
  );

  wdog_timer #(
    .LONG_EXP (WD_LONG_EXP),
    .SHORT_EXP(WD_SHORT_EXP),
    .SUB_EXP  (WD_SUB_EXP)
  ) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_off   (cfg_q.wd_off),
    .short_sel(cfg_q.wd_short),
    .service  (wd_service),
    .expire_q (wd_rst_req),
    .hit_now  (wd_hit_now)
  );

  stop_seq #(
    .SHORT_REC(REC_SHORT),
    .LONG_REC (REC_LONG)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_en  (cfg_q.stop_en),
    .short_rec(cfg_q.short_rec),
    .stop_req (stop_req),
    .wake_req (wake_req),
    .wake_rst (wake_rst),
    .phase_q  (seq_phase),
    .done_q   (rec_done),
    .illegal_q(stop_illegal)
  );

endmodule

// File: rtl/sysopt_ctrl_chk.sv
module sysopt_ctrl_chk
  import cfgwd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cfg_q,
  input logic       cfg_locked,
  input logic       cfg_wr_hit,
  input logic [7:0] bus_rdata,
  input logic       wd_hit_now,
  input logic       wd_rst_req,
  input logic       stop_req,
  input phase_t     seq_phase,
  input logic       stop_illegal,
  input logic       rec_done
);

  p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:4] == 4'h0);

  p_first_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_hit && !cfg_locked |=> cfg_locked);

  p_lock_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> $stable(cfg_q) && cfg_locked);

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> !rec_done);

  p_wd_from_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit_now |=> wd_rst_req);

  p_wd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_req |=> !wd_rst_req);

  p_wd_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[0] && $past(cfg_q[0]) |-> !wd_rst_req);

  p_illegal_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !cfg_q[1] && seq_phase == PH_RUN |=> stop_illegal && seq_phase == PH_RUN);

  p_legal_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && cfg_q[1] && seq_phase == PH_RUN |=> !stop_illegal && seq_phase == PH_STOP);

endmodule

bind sysopt_ctrl sysopt_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_q       (cfg_q),
  .cfg_locked  (cfg_locked),
  .cfg_wr_hit  (cfg_wr_hit),
  .bus_rdata   (bus_rdata),
  .wd_hit_now  (wd_hit_now),
  .wd_rst_req  (wd_rst_req),
  .stop_req    (stop_req),
  .seq_phase   (seq_phase),
  .stop_illegal(stop_illegal),
  .rec_done    (rec_done)
);

// File: tb/sysopt_ctrl_tb.sv
`timescale 1ns/1ps
module sysopt_ctrl_tb;

  localparam int LE  = 10;
  localparam int SE  = 7;
  localparam int SUB = 4;
  localparam int T_L = (1 << LE) - (1 << SUB);  // 1008
  localparam int T_S = (1 << SE) - (1 << SUB);  // 112
  localparam int D_S = 32;
  localparam int D_L = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wd_service = 1'b0, stop_req = 1'b0, wake_req = 1'b0, wake_rst = 1'b0;
  logic       wd_rst_req, rec_done, stop_illegal;

  sysopt_ctrl #(
    .WD_LONG_EXP (LE),
    .WD_SHORT_EXP(SE),
    .WD_SUB_EXP  (SUB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_service(wd_service), .stop_req(stop_req), .wake_req(wake_req),
    .wake_rst(wake_rst), .wd_rst_req(wd_rst_req), .rec_done(rec_done),
    .stop_illegal(stop_illegal)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard queues: expected latency and the requirement it belongs to.
  int    wd_q[$];
  string wd_tag_q[$];
  int    rec_q[$];
  string rec_tag_q[$];
  int    wd_mark = 0, rec_mark = 0;
  int    wd_seen = 0, rec_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops an expectation for every pulse seen.
  always @(negedge clk) begin : mon
    int    e;
    string t;
    if (rst_n) begin
      if (wd_rst_req) begin
        wd_seen++;
        if (wd_q.size() == 0) chk(1'b0, "R9 unexpected watchdog request", 1, 0);
        else begin
          e = wd_q.pop_front();
          t = wd_tag_q.pop_front();
          chk(cyc - wd_mark == e, t, cyc - wd_mark, e);
        end
        wd_mark = cyc;
      end
      if (rec_done) begin
        rec_seen++;
        if (rec_q.size() == 0) chk(1'b0, "R11 unexpected recovery done", 1, 0);
        else begin
          e = rec_q.pop_front();
          t = rec_tag_q.pop_front();
          chk(cyc - rec_mark == e, t, cyc - rec_mark, e);
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_sel = 0; bus_wr = 0; wd_service = 0; stop_req = 0; wake_req = 0; wake_rst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wd_mark = cyc;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic enter_stop();
    @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
  endtask

  task automatic wake(input bit via_rst, input int exp, input string tag);
    @(negedge clk);
    if (via_rst) wake_rst = 1; else wake_req = 1;
    rec_mark = cyc + 1;
    rec_q.push_back(exp);
    rec_tag_q.push_back(tag);
    @(negedge clk);
    wake_req = 0; wake_rst = 0;
  endtask

  task automatic service();
    @(negedge clk);
    wd_service = 1;
    wd_mark = cyc + 1;
    @(negedge clk);
    wd_service = 0;
  endtask

  task automatic push_wd(input int exp, input string tag);
    wd_q.push_back(exp);
    wd_tag_q.push_back(tag);
  endtask

  task automatic wait_drain(input int limit, input string tag);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wd_q.size() == 0 && rec_q.size() == 0) break;
    end
    chk(wd_q.size() + rec_q.size() == 0, tag, wd_q.size() + rec_q.size(), 0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : drv
    logic [7:0] d;
    int seen;

    // Phase A: short recovery, watchdog off, stop allowed.
    do_reset();
    rd(8'h1F, d);
    chk(d == 8'h00, "R1 reset value", d, 0);
    chk(!wd_rst_req && !rec_done && !stop_illegal, "R1 outputs low", 1, 0);
    wr(8'h1E, 8'hFF);
    rd(8'h1F, d);
    chk(d == 8'h00, "R3 other address no effect", d, 0);
    wr(8'h1F, 8'hFB);
    rd(8'h1F, d);
    chk(d == 8'h0B, "R2 first write stored", d, 8'h0B);
    wr(8'h1F, 8'h00);
    rd(8'h1F, d);
    chk(d == 8'h0B, "R3 second write ignored", d, 8'h0B);
    repeat (1500) @(negedge clk);
    chk(wd_seen == 0, "R9 watchdog off", wd_seen, 0);
    seen = rec_seen;
    wake(1'b0, 0, "unused");
    void'(rec_q.pop_back()); void'(rec_tag_q.pop_back());
    repeat (40) @(negedge clk);
    chk(rec_seen == seen, "R11 wake while running ignored", rec_seen, seen);
    enter_stop();
    chk(!stop_illegal, "R11 legal stop not flagged", stop_illegal, 0);
    wake(1'b0, D_S, "R4 short recovery");
    wait_drain(100, "R4 drained");
    enter_stop();
    wake(1'b1, D_L, "R6 reset exit long recovery");
    wait_drain(4200, "R6 drained");

    // Phase B: short watchdog period, stop not allowed.
    do_reset();
    push_wd(T_S, "R7 short period from reset");
    wr(8'h1F, 8'h04);
    rd(8'h1F, d);
    chk(d == 8'h04, "R2 value 0x04 stored", d, 4);
    @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
    chk(stop_illegal == 1'b1, "R10 illegal flag set", stop_illegal, 1);
    @(negedge clk);
    chk(stop_illegal == 1'b0, "R10 illegal flag one cycle", stop_illegal, 0);
    seen = rec_seen;
    wake(1'b0, 0, "unused");
    void'(rec_q.pop_back()); void'(rec_tag_q.pop_back());
    repeat (30) @(negedge clk);
    chk(rec_seen == seen, "R10 no stop entered", rec_seen, seen);
    push_wd(T_S, "R7 short period repeat");
    push_wd(T_S, "R7 short period repeat");
    wait_drain(500, "R7 short drained");
    repeat (50) @(negedge clk);
    service();
    push_wd(T_S, "R8 period after service");
    repeat (60) @(negedge clk);
    service();
    wait_drain(300, "R8 drained");

    // Phase C: long watchdog period, lock attempts.
    do_reset();
    push_wd(T_L, "R7 long period from reset");
    push_wd(T_L, "R7 long period repeat");
    wr(8'h1F, 8'h00);
    wr(8'h1F, 8'h01);
    rd(8'h1F, d);
    chk(d == 8'h00, "R3 zero write still locks", d, 0);
    wait_drain(2200, "R7 long drained");

    // Phase D: long recovery, watchdog off.
    do_reset();
    wr(8'h1F, 8'h03);
    enter_stop();
    wake(1'b0, D_L, "R5 long recovery");
    wait_drain(4200, "R5 drained");

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule